// File: doc/BRIEF.md
# Test Instruction Register and Data-Path Selector

This block sits beside a test access port state machine and runs on the test clock. It holds a 4-bit instruction that is shifted in serially and made active by an update strobe. The active instruction decides which test data register is placed between the serial input and the serial output. The choices are the external boundary register, a 32-bit identification register, or a single-stage bypass flop. The instruction also sets the pin controls that the boundary cells use: a mode select, which hands the pins to the boundary register, and an output enable, which can put every output in high impedance.

The capture, shift and update strobes for the instruction register and for the data registers come from the state machine. The data-register strobes are passed on to the boundary cells only while the boundary register is the selected path. For the built-in self-test, the block gives out a one-cycle start pulse and samples a single result bit. The self-test engine itself is outside the block.

Instruction codes: 0000 EXTEST, 0001 IDCODE, 0010 SAMPLE/PRELOAD, 0011 INTEST, 0100 RUNBIST, 0101 CLAMP, 0110 HIGHZ, 0111 USERCODE, 1111 BYPASS. Every other code behaves as BYPASS. All serial transfers move the least significant bit first.

Top module: `jtag_irdr_sel`

## Requirements
- R1: While trst_n is low, and after it is released, the active instruction is IDCODE (0001). In that state pin_oe=1, mode_ctl=0, bist_start=0, and a data scan returns the identification value.
- R2: A Capture-IR cycle loads 0001 into the instruction shift stage. During Shift-IR, tdo shows bit 0 of that stage, so the first four shifted-out bits are 1,0,0,0.
- R3: Shift-IR moves tdi in at bit 3, least significant bit first. The active instruction changes only on an Update-IR cycle. Shifting without an update leaves the pin controls and the data path as they were.
- R4: Under IDCODE, Capture-DR loads the identification value, which is shifted out least significant bit first. Bit 0 is 1, bits 11:1 hold the manufacturer code, bits 27:12 hold the part number and bits 31:28 hold the version.
- R5: Under USERCODE, Capture-DR loads user_code into the identification path, which is then shifted out least significant bit first.
- R6: Under BYPASS and under any unassigned code, the serial path is one flop that captures 0. On each shift tdo shows the tdi of the previous shift. Pins are in normal mode: mode_ctl=0 and pin_oe=1.
- R7: Under EXTEST, SAMPLE/PRELOAD and INTEST, tdo follows bsr_tdo during Shift-DR. The three DR strobes appear on the bsr_capture, bsr_shift and bsr_update outputs, and those outputs stay low under every other instruction. mode_ctl is 1 for EXTEST and INTEST and 0 for SAMPLE/PRELOAD.
- R8: Under CLAMP, mode_ctl=1 and pin_oe=1, and the bypass flop forms the serial path.
- R9: Under HIGHZ, pin_oe=0 and mode_ctl=1, and the bypass flop forms the serial path.
- R10: Under RUNBIST, mode_ctl=1 and the bypass flop is the serial path. An rti_enter cycle makes bist_start high for exactly the next cycle. Capture-DR loads bist_result into the bypass flop. Under any other instruction, bist_start stays 0.
- R11: With HAS_ID=0, reset selects BYPASS, and IDCODE and USERCODE also act as BYPASS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low test reset |
| tdi | input | 1 | Serial test data input |
| ir_capture | input | 1 | Capture-IR strobe |
| ir_shift | input | 1 | Shift-IR strobe |
| ir_update | input | 1 | Update-IR strobe |
| dr_capture | input | 1 | Capture-DR strobe |
| dr_shift | input | 1 | Shift-DR strobe |
| dr_update | input | 1 | Update-DR strobe |
| rti_enter | input | 1 | Pulse when the controller enters Run-Test/Idle |
| bsr_tdo | input | 1 | Serial output of the external boundary register |
| bist_result | input | 1 | Self-test pass/fail bit |
| user_code | input | 32 | User-programmed identification value |
| tdo | output | 1 | Serial test data output |
| bsr_capture | output | 1 | Capture strobe for the boundary cells |
| bsr_shift | output | 1 | Shift strobe for the boundary cells |
| bsr_update | output | 1 | Update strobe for the boundary cells |
| mode_ctl | output | 1 | Boundary register drives the pins when 1 |
| pin_oe | output | 1 | Output enable; 0 forces high impedance |
| bist_start | output | 1 | One-cycle self-test start pulse |

## Verification
The assertions assume that the state machine raises at most one of the six strobes in any cycle. They also assume that rti_enter and the strobes are synchronous to tck. The bench drives every scan as a fixed sequence: one capture cycle, then the shift cycles, then one update cycle. Between scans all strobes are low, so the one-hot assumption always holds. Random instruction codes, random shift data, random user codes and random result bits are applied only inside that sequence.

// File: rtl/jtag_sel_pkg.sv
`timescale 1ns/1ps
package jtag_sel_pkg;
  localparam int IR_W = 4;
  localparam int ID_W = 32;

  localparam logic [IR_W-1:0] C_EXTEST   = 4'b0000;
  localparam logic [IR_W-1:0] C_IDCODE   = 4'b0001;
  localparam logic [IR_W-1:0] C_SAMPLE   = 4'b0010;
  localparam logic [IR_W-1:0] C_INTEST   = 4'b0011;
  localparam logic [IR_W-1:0] C_RUNBIST  = 4'b0100;
  localparam logic [IR_W-1:0] C_CLAMP    = 4'b0101;
  localparam logic [IR_W-1:0] C_HIGHZ    = 4'b0110;
  localparam logic [IR_W-1:0] C_USERCODE = 4'b0111;
  localparam logic [IR_W-1:0] C_BYPASS   = 4'b1111;
  localparam logic [IR_W-1:0] C_IR_CAPT  = 4'b0001;

  typedef enum logic [1:0] {PATH_BSR, PATH_ID, PATH_BYP} path_e;

  typedef struct packed {
    path_e path;
    logic  mode_ctl;
    logic  pin_oe;
    logic  runbist;
    logic  usercode;
  } dec_t;

  function automatic dec_t decode_instr(input logic [IR_W-1:0] code, input bit has_id);
    dec_t d;
    d.path     = PATH_BYP;
    d.mode_ctl = 1'b0;
    d.pin_oe   = 1'b1;
    d.runbist  = 1'b0;
    d.usercode = 1'b0;
    case (code)
      C_EXTEST:  begin d.path = PATH_BSR; d.mode_ctl = 1'b1; end
      C_SAMPLE:  d.path = PATH_BSR;
      C_INTEST:  begin d.path = PATH_BSR; d.mode_ctl = 1'b1; end
      C_IDCODE:  if (has_id) d.path = PATH_ID;
      C_USERCODE: if (has_id) begin d.path = PATH_ID; d.usercode = 1'b1; end
      C_RUNBIST: begin d.mode_ctl = 1'b1; d.runbist = 1'b1; end
      C_CLAMP:   d.mode_ctl = 1'b1;
      C_HIGHZ:   begin d.mode_ctl = 1'b1; d.pin_oe = 1'b0; end
      default:   d.path = PATH_BYP;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/jtag_ir_reg.sv
`timescale 1ns/1ps
module jtag_ir_reg
  import jtag_sel_pkg::*;
#(
  parameter logic [IR_W-1:0] RESET_CODE = C_IDCODE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            shift,
  input  logic            update,
  input  logic            tdi,
  output logic            sr_lsb,
  output logic [IR_W-1:0] ir_q
);
  logic [IR_W-1:0] sr_q, sr_d, q_d;

  always_comb begin
    sr_d = sr_q;
    if (capture)    sr_d = C_IR_CAPT;
    else if (shift) sr_d = {tdi, sr_q[IR_W-1:1]};
  end

  always_comb begin
    q_d = ir_q;
    if (update) q_d = sr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= C_IR_CAPT;
      ir_q <= RESET_CODE;
    end else begin
      if (capture || shift) sr_q <= sr_d;
      if (update)           ir_q <= q_d;
    end
  end

  assign sr_lsb = sr_q[0];

  AST_IR_CAPTURE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (sr_q == 4'b0001)); // R2
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(ir_q)); // R3
endmodule

// File: rtl/jtag_id_reg.sv
`timescale 1ns/1ps
module jtag_id_reg
  import jtag_sel_pkg::*;
#(
  parameter logic [ID_W-1:0] ID_VAL = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            capture,
  input  logic            shift,
  input  logic            sel,
  input  logic            use_user,
  input  logic [ID_W-1:0] user_code,
  input  logic            tdi,
  output logic            tdo
);
  logic [ID_W-1:0] sr_q, sr_d;
  logic            en;

  assign en = sel && (capture || shift);

  always_comb begin
    sr_d = sr_q;
    if (capture)    sr_d = use_user ? user_code : ID_VAL;
    else if (shift) sr_d = {tdi, sr_q[ID_W-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  sr_q <= ID_VAL;
    else if (en) sr_q <= sr_d;
  end

  assign tdo = sr_q[0];

  AST_ID_MARKER_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && sel && !use_user) |=> tdo); // R4
endmodule

// File: rtl/jtag_bypass_reg.sv
`timescale 1ns/1ps
module jtag_bypass_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic capture,
  input  logic shift,
  input  logic sel,
  input  logic cap_val,
  input  logic tdi,
  output logic q
);
  logic d;

  always_comb begin
    d = q;
    if (capture)    d = cap_val;
    else if (shift) d = tdi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        q <= 1'b0;
    else if (sel && (capture || shift)) q <= d;
  end

  AST_BYP_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && shift) |=> (q == $past(tdi))); // R6
endmodule

// File: rtl/jtag_irdr_sel.sv
`timescale 1ns/1ps
module jtag_irdr_sel
  import jtag_sel_pkg::*;
#(
  parameter bit          HAS_ID     = 1'b1,
  parameter logic [3:0]  ID_VERSION = 4'h3,
  parameter logic [15:0] ID_PART    = 16'hA5C1,
  parameter logic [10:0] ID_MFR     = 11'h2B5
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            tdi,
  input  logic            ir_capture,
  input  logic            ir_shift,
  input  logic            ir_update,
  input  logic            dr_capture,
  input  logic            dr_shift,
  input  logic            dr_update,
  input  logic            rti_enter,
  input  logic            bsr_tdo,
  input  logic            bist_result,
  input  logic [ID_W-1:0] user_code,
  output logic            tdo,
  output logic            bsr_capture,
  output logic            bsr_shift,
  output logic            bsr_update,
  output logic            mode_ctl,
  output logic            pin_oe,
  output logic            bist_start
);
  localparam logic [ID_W-1:0] ID_VAL = {ID_VERSION, ID_PART, ID_MFR, 1'b1};
  localparam logic [IR_W-1:0] RST_CODE = HAS_ID ? C_IDCODE : C_BYPASS;

  // reset: asserted asynchronously, released on the test clock
  logic rst_meta, rst_n;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      rst_meta <= 1'b0;
      rst_n    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n    <= rst_meta;
    end
  end

  logic [IR_W-1:0] ir_q;
  logic            ir_lsb;
  dec_t            dec;
  logic            id_tdo, byp_q, byp_cap;
  logic            sel_id, sel_byp, sel_bsr;
  logic            start_d;

  jtag_ir_reg #(.RESET_CODE(RST_CODE)) u_ir (
    .clk(tck), .rst_n(rst_n), .capture(ir_capture), .shift(ir_shift),
    .update(ir_update), .tdi(tdi), .sr_lsb(ir_lsb), .ir_q(ir_q)
  );

  always_comb dec = decode_instr(ir_q, HAS_ID);

  assign sel_id  = (dec.path == PATH_ID);
  assign sel_byp = (dec.path == PATH_BYP);
  assign sel_bsr = (dec.path == PATH_BSR);

  generate
    if (HAS_ID) begin : g_id
      jtag_id_reg #(.ID_VAL(ID_VAL)) u_id (
        .clk(tck), .rst_n(rst_n), .capture(dr_capture), .shift(dr_shift),
        .sel(sel_id), .use_user(dec.usercode), .user_code(user_code),
        .tdi(tdi), .tdo(id_tdo)
      );
    end else begin : g_no_id
      logic unused_user;
      assign unused_user = ^{user_code, sel_id};
      assign id_tdo = 1'b0;
    end
  endgenerate

  assign byp_cap = dec.runbist & bist_result;

  jtag_bypass_reg u_byp (
    .clk(tck), .rst_n(rst_n), .capture(dr_capture), .shift(dr_shift),
    .sel(sel_byp), .cap_val(byp_cap), .tdi(tdi), .q(byp_q)
  );

  // self-test start pulse
  assign start_d = rti_enter && dec.runbist;
  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) bist_start <= 1'b0;
    else        bist_start <= start_d;
  end

  always_comb begin
    if (ir_shift) tdo = ir_lsb;
    else begin
      case (dec.path)
        PATH_BSR: tdo = bsr_tdo;
        PATH_ID:  tdo = id_tdo;
        default:  tdo = byp_q;
      endcase
    end
  end

  assign bsr_capture = dr_capture & sel_bsr;
  assign bsr_shift   = dr_shift   & sel_bsr;
  assign bsr_update  = dr_update  & sel_bsr;
  assign mode_ctl    = dec.mode_ctl;
  assign pin_oe      = dec.pin_oe;

  AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!rst_n)
    $onehot0({ir_capture, ir_shift, ir_update, dr_capture, dr_shift, dr_update})); // R3
  AST_HIGHZ_OE_OFF: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q == C_HIGHZ) |-> !pin_oe); // R9
  AST_BIST_START_CAUSE: assert property (@(posedge tck) disable iff (!rst_n)
    bist_start |-> $past(rti_enter)); // R10
  AST_BSR_STROBE_IDLE: assert property (@(posedge tck) disable iff (!rst_n)
    (ir_q == C_CLAMP) |-> !(bsr_capture || bsr_shift || bsr_update)); // R8
endmodule

// File: tb/jtag_irdr_sel_bench.sv
`timescale 1ns/1ps
module jtag_irdr_sel_bench;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tdi = 1'b0;
  logic ir_capture = 1'b0, ir_shift = 1'b0, ir_update = 1'b0;
  logic dr_capture = 1'b0, dr_shift = 1'b0, dr_update = 1'b0;
  logic rti_enter = 1'b0, bsr_tdo = 1'b0, bist_result = 1'b0;
  logic [31:0] user_code = 32'h0;
  logic tdo, bsr_capture, bsr_shift, bsr_update, mode_ctl, pin_oe, bist_start;
  logic tdo_n, bc_n, bs_n, bu_n, mc_n, oe_n, bst_n;

  int n_tests = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [31:0] EXP_ID = {4'h3, 16'hA5C1, 11'h2B5, 1'b1};

  always #10 tck = ~tck;

  jtag_irdr_sel #(.HAS_ID(1'b1), .ID_VERSION(4'h3), .ID_PART(16'hA5C1), .ID_MFR(11'h2B5))
  u_jtag_irdr_sel (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .ir_capture(ir_capture), .ir_shift(ir_shift),
    .ir_update(ir_update), .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .rti_enter(rti_enter), .bsr_tdo(bsr_tdo), .bist_result(bist_result), .user_code(user_code),
    .tdo(tdo), .bsr_capture(bsr_capture), .bsr_shift(bsr_shift), .bsr_update(bsr_update),
    .mode_ctl(mode_ctl), .pin_oe(pin_oe), .bist_start(bist_start)
  );

  jtag_irdr_sel #(.HAS_ID(1'b0)) u_noid (
    .tck(tck), .trst_n(trst_n), .tdi(tdi), .ir_capture(ir_capture), .ir_shift(ir_shift),
    .ir_update(ir_update), .dr_capture(dr_capture), .dr_shift(dr_shift), .dr_update(dr_update),
    .rti_enter(rti_enter), .bsr_tdo(bsr_tdo), .bist_result(bist_result), .user_code(user_code),
    .tdo(tdo_n), .bsr_capture(bc_n), .bsr_shift(bs_n), .bsr_update(bu_n),
    .mode_ctl(mc_n), .pin_oe(oe_n), .bist_start(bst_n)
  );

  // expected-value model from the requirements
  function automatic int exp_path(input logic [3:0] c); // 0 bsr, 1 id, 2 bypass
    if (c == 4'h0 || c == 4'h2 || c == 4'h3) return 0;
    if (c == 4'h1 || c == 4'h7) return 1;
    return 2;
  endfunction
  function automatic logic exp_mode(input logic [3:0] c);
    return (c == 4'h0 || c == 4'h3 || c == 4'h4 || c == 4'h5 || c == 4'h6);
  endfunction
  function automatic logic exp_oe(input logic [3:0] c);
    return (c != 4'h6);
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  task automatic ir_scan(input logic [3:0] code, input bit upd, output logic [3:0] got);
    @(negedge tck); ir_capture = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge tck); ir_capture = 1'b0; ir_shift = 1'b1; tdi = code[i];
      #2 got[i] = tdo;
    end
    @(negedge tck); ir_shift = 1'b0; ir_update = upd;
    @(negedge tck); ir_update = 1'b0;
    #2;
  endtask

  task automatic dr_scan(input logic [32:0] din, output logic [32:0] got,
                         output logic [32:0] got_n, output logic [32:0] bsr_seen,
                         output bit gate_hi, output bit gate_lo);
    gate_hi = 1'b1; gate_lo = 1'b1;
    @(negedge tck); dr_capture = 1'b1;
    #2 if (bsr_capture) gate_lo = 1'b0; else gate_hi = 1'b0;
    for (int i = 0; i < 33; i++) begin
      @(negedge tck); dr_capture = 1'b0; dr_shift = 1'b1; tdi = din[i];
      bsr_tdo = 1'($urandom); bsr_seen[i] = bsr_tdo;
      #2 got[i] = tdo; got_n[i] = tdo_n;
      if (bsr_shift) gate_lo = 1'b0; else gate_hi = 1'b0;
    end
    @(negedge tck); dr_shift = 1'b0; dr_update = 1'b1;
    #2 if (bsr_update) gate_lo = 1'b0; else gate_hi = 1'b0;
    @(negedge tck); dr_update = 1'b0;
    #2;
  endtask

  task automatic check_dr(input logic [3:0] c, input string req);
    logic [32:0] din, got, got_n, bsr_seen, exp;
    bit gh, gl;
    logic cap;
    din = {1'($urandom), $urandom};
    cap = (c == 4'h4) ? bist_result : 1'b0;
    dr_scan(din, got, got_n, bsr_seen, gh, gl);
    case (exp_path(c))
      0: begin
        exp = bsr_seen;
        check(gh, {req, " R7 bsr strobes"}, 0, 1);
      end
      1: begin
        exp = {din[0], (c == 4'h7) ? user_code : EXP_ID};
        check(gl, {req, " R7 bsr strobes idle"}, 1, 0);
      end
      default: begin
        exp = {din[31:0], cap};
        check(gl, {req, " R7 bsr strobes idle"}, 1, 0);
      end
    endcase
    check(got == exp, req, 64'(got), 64'(exp));
  endtask

  initial begin
    #(200000 * 20);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [3:0] cur, got4;
    logic [32:0] din, got, got_n, seen;
    bit gh, gl;
    void'($urandom(32'd2468));
    repeat (3) @(negedge tck);
    // R1 values while reset is held
    check(pin_oe == 1'b1 && mode_ctl == 1'b0 && bist_start == 1'b0, "R1 pins in reset",
          {pin_oe, mode_ctl, bist_start}, 3'b100);
    trst_n = 1'b1;
    repeat (4) @(negedge tck);
    check(pin_oe == 1'b1 && mode_ctl == 1'b0, "R1 pins after reset", {pin_oe, mode_ctl}, 2'b10);
    // R1/R4 identification value after reset; R11 bypass without id
    din = 33'h1_3C5A_96E1;
    dr_scan(din, got, got_n, seen, gh, gl);
    check(got == {din[0], EXP_ID}, "R1 R4 id after reset", 64'(got), 64'({din[0], EXP_ID}));
    check(got_n == {din[31:0], 1'b0}, "R11 no-id reset bypass", 64'(got_n), 64'({din[31:0], 1'b0}));
    // R11 IDCODE on the no-id variant still bypasses
    ir_scan(4'h1, 1'b1, got4);
    dr_scan(din, got, got_n, seen, gh, gl);
    check(got_n == {din[31:0], 1'b0}, "R11 no-id IDCODE bypass", 64'(got_n), 64'({din[31:0], 1'b0}));

    // R9 HIGHZ
    ir_scan(4'h6, 1'b1, got4);
    check(got4 == 4'b0001, "R2 capture pattern", got4, 4'b0001);
    check(pin_oe == 1'b0 && mode_ctl == 1'b1, "R9 highz pins", {pin_oe, mode_ctl}, 2'b01);
    check_dr(4'h6, "R9 highz bypass path");
    // R3 shift without update keeps HIGHZ
    ir_scan(4'h0, 1'b0, got4);
    check(pin_oe == 1'b0 && mode_ctl == 1'b1, "R3 no update keeps instr", {pin_oe, mode_ctl}, 2'b01);
    check_dr(4'h6, "R3 path kept");
    // R8 CLAMP
    ir_scan(4'h5, 1'b1, got4);
    check(pin_oe == 1'b1 && mode_ctl == 1'b1, "R8 clamp pins", {pin_oe, mode_ctl}, 2'b11);
    check_dr(4'h5, "R8 clamp bypass path");
    // R5 USERCODE
    user_code = 32'hDEAD_BEEF;
    ir_scan(4'h7, 1'b1, got4);
    check_dr(4'h7, "R5 usercode");
    // R7 SAMPLE keeps pins normal
    ir_scan(4'h2, 1'b1, got4);
    check(mode_ctl == 1'b0 && pin_oe == 1'b1, "R7 sample pins", {mode_ctl, pin_oe}, 2'b01);
    check_dr(4'h2, "R7 sample path");
    // R10 RUNBIST start pulse and result capture
    ir_scan(4'h4, 1'b1, got4);
    check(mode_ctl == 1'b1, "R10 runbist mode", mode_ctl, 1);
    bist_result = 1'b1;
    @(negedge tck); rti_enter = 1'b1;
    @(negedge tck); rti_enter = 1'b0;
    #2 check(bist_start == 1'b1, "R10 start pulse high", bist_start, 1);
    @(negedge tck); #2 check(bist_start == 1'b0, "R10 start pulse one cycle", bist_start, 0);
    check_dr(4'h4, "R10 result captured");
    // R6 unassigned code; no start pulse outside RUNBIST
    ir_scan(4'hA, 1'b1, got4);
    @(negedge tck); rti_enter = 1'b1;
    @(negedge tck); rti_enter = 1'b0;
    #2 check(bist_start == 1'b0, "R10 no start outside runbist", bist_start, 0);
    check(mode_ctl == 1'b0 && pin_oe == 1'b1, "R6 unassigned pins", {mode_ctl, pin_oe}, 2'b01);
    check_dr(4'hA, "R6 unassigned bypass");

    // random instructions and data
    for (int k = 0; k < 60; k++) begin
      cur = 4'($urandom);
      user_code = $urandom;
      bist_result = 1'($urandom);
      ir_scan(cur, 1'b1, got4);
      check(got4 == 4'b0001, "R2 capture pattern", got4, 4'b0001);
      check(mode_ctl == exp_mode(cur) && pin_oe == exp_oe(cur), "R7 R8 R9 pin controls",
            {mode_ctl, pin_oe}, {exp_mode(cur), exp_oe(cur)});
      case (exp_path(cur))
        0: check_dr(cur, "R7 boundary path");
        1: check_dr(cur, "R4 R5 id path");
        default: check_dr(cur, "R6 bypass path");
      endcase
    end
    finish_run();
  end
endmodule